// File: doc/BRIEF.md
# A20 Gate and Reset Pulser

This block holds the system-control byte of a PC-style keyboard controller output port. The controller's command path replaces the whole byte with a write, and it can read the stored byte back at any time. Two of the byte's bits drive board-level signals. Bit 0 is the active-low system reset line. Bit 1 is the address line 20 gate.

A pulse command carries a 4-bit mask that covers the four low-order port bits. Each bit whose mask position is 0 is driven low for a fixed time of six microseconds. After that time the bit shows the stored register value again. A mask position of 1 leaves its bit alone. A pulse on bit 0 therefore resets the CPU. A pulse on bit 1 closes the gate for the length of the pulse.

The block also registers the CPU address on its way to memory. When the gate is closed, address bit 20 is forced to zero, so addresses wrap at 1 MB as they did on the old 20-bit processors. When the gate is open, the address passes through unchanged. Bus decoding belongs to the surrounding controller.

Top module: `a20_reset_ctl`

## Requirements
- R1: After reset the stored port byte reads 0xDF. The reset line is high, the gate is high, and the registered address is zero.
- R2: A write strobe replaces all eight bits of the stored byte. From the next cycle on, the read port returns the new byte.
- R3: While no pulse runs, the reset line equals stored bit 0 and the gate equals stored bit 1.
- R4: A pulse command is sampled on a clock edge. Each port bit whose mask position is 0 reads low for exactly 6*CLK_PER_US cycles, starting in the cycle after the command. After that, the bit reads its stored value again.
- R5: Mask positions that are 1 leave their bits unchanged. A mask of 4'b1111 starts no pulse at all.
- R6: A pulse command that arrives while a pulse runs is ignored. It neither extends the running pulse nor adds bits to it.
- R7: While the gate level is low, the address output one cycle later equals the input address with bit 20 cleared. All other bits pass through.
- R8: While the gate level is high, the address output one cycle later equals the input address unchanged.
- R9: A pulse on bit 1 closes the gate for the duration of the pulse. Address bit 20 is masked during those cycles.
- R10: The read port returns the stored byte, not the pulsed levels. A write during a pulse takes effect on the outputs once the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_we_i | input | 1 | Output port write strobe |
| port_wdata_i | input | 8 | Byte to store in the output port |
| port_rdata_o | output | 8 | Stored output port byte |
| pulse_req_i | input | 1 | Pulse command strobe |
| pulse_mask_i | input | 4 | Pulse mask, 0 selects a bit to pulse low |
| addr_i | input | ADDR_W | CPU address |
| addr_o | output | ADDR_W | Registered address, bit 20 masked when the gate is low |
| sys_reset_no | output | 1 | System reset line, active low |
| a20_gate_o | output | 1 | Gate level for address line 20 |

## Verification
The bench first moves addresses with bit 20 set and with bit 20 clear through the block while the gate is open. It then repeats them with the gate closed by a port write, and again with the gate closed only by a pulse. This tells a static mask apart from a timed one. Pulses are tried on bit 0 alone, on bit 1 alone and on bit 2 alone, and with an all-ones mask. Watching the reset line while an unrelated bit pulses shows whether the unselected bits leak. A command sent in the middle of a running pulse shows whether the block ignores it or restarts. A port write made during a pulse separates the stored byte from the pulsed levels.

// File: rtl/a20_pkg.sv
package a20_pkg;
  localparam int unsigned PORT_W     = 8;
  localparam int unsigned MASK_W     = 4;
  localparam int unsigned RST_BIT    = 0;
  localparam int unsigned GATE_BIT   = 1;
  localparam int unsigned WRAP_BIT   = 20;
  localparam logic [PORT_W-1:0] PORT_RESET = 8'hDF;
endpackage

// File: rtl/a20_port_reg.sv
module a20_port_reg
  import a20_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= PORT_RESET;
    else if (we_i) q_o <= wdata_i;
  end

  p_write_whole_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i)));
endmodule

// File: rtl/a20_pulse_timer.sv
module a20_pulse_timer
  import a20_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [MASK_W-1:0] low_o,
  output logic              busy_o
);
  localparam int unsigned CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          start;

  // all-ones mask selects nothing, so it never occupies the timer
  assign start = req_i && !busy_o && (mask_i != '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      low_o  <= '0;
      busy_o <= 1'b0;
    end else if (busy_o) begin
      if (cnt_q == '0) begin
        busy_o <= 1'b0;
        low_o  <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_o <= 1'b1;
      low_o  <= ~mask_i;
      cnt_q  <= LOAD;
    end
  end

  p_load_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (cnt_q == LOAD));
  p_no_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != '0) |=> (busy_o && $stable(low_o) && cnt_q == $past(cnt_q) - 1'b1));
  p_all_ones_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && mask_i == '1) |=> !busy_o);
  p_low_only_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (low_o == '0));
endmodule

// File: rtl/a20_addr_mask.sv
module a20_addr_mask
  import a20_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] WRAP_CLR = ~(ADDR_W'(1) << WRAP_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (gate_i) addr_o <= addr_i;
    else             addr_o <= addr_i & WRAP_CLR;
  end

  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> (addr_o[WRAP_BIT] == 1'b0));
  p_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |=> (addr_o == $past(addr_i)));
endmodule

// File: rtl/a20_reset_ctl.sv
module a20_reset_ctl
  import a20_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 4,
  parameter int unsigned PULSE_US   = 6,
  parameter int unsigned ADDR_W     = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_we_i,
  input  logic [7:0]        port_wdata_i,
  output logic [7:0]        port_rdata_o,
  input  logic              pulse_req_i,
  input  logic [3:0]        pulse_mask_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sys_reset_no,
  output logic              a20_gate_o
);
  localparam int unsigned PULSE_CYC = PULSE_US * CLK_PER_US;

  logic [PORT_W-1:0] port_q;
  logic [PORT_W-1:0] pins;
  logic [MASK_W-1:0] low;
  logic              busy;

  a20_port_reg u_port (
    .clk_i, .rst_ni, .we_i(port_we_i), .wdata_i(port_wdata_i), .q_o(port_q)
  );

  a20_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk_i, .rst_ni, .req_i(pulse_req_i), .mask_i(pulse_mask_i),
    .low_o(low), .busy_o(busy)
  );

  assign pins         = port_q & ~{{(PORT_W-MASK_W){1'b0}}, low};
  assign sys_reset_no = pins[RST_BIT];
  assign a20_gate_o   = pins[GATE_BIT];
  assign port_rdata_o = port_q;

  a20_addr_mask #(.ADDR_W(ADDR_W)) u_mask (
    .clk_i, .rst_ni, .gate_i(a20_gate_o), .addr_i, .addr_o
  );

  p_idle_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sys_reset_no == port_rdata_o[RST_BIT] && a20_gate_o == port_rdata_o[GATE_BIT]));
  p_pulse_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && low[RST_BIT]) |-> !sys_reset_no);
  p_gate_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && low[GATE_BIT]) |=> (addr_o[WRAP_BIT] == 1'b0));
endmodule

// File: tb/a20_reset_ctl_tb_top.sv
module a20_reset_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPU  = 4;
  localparam int PULS = 6 * CPU;
  localparam int AW   = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          req = 1'b0;
  logic [3:0]    mask = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] addr_q;
  logic          rst_line, gate;

  a20_reset_ctl #(.CLK_PER_US(CPU), .PULSE_US(6), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .port_we_i(we), .port_wdata_i(wdata),
    .port_rdata_o(rdata), .pulse_req_i(req), .pulse_mask_i(mask),
    .addr_i(addr), .addr_o(addr_q), .sys_reset_no(rst_line), .a20_gate_o(gate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    string       tag;
    logic        rst;
    logic        gt;
    logic [7:0]  rd;
    logic [AW-1:0] ad;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;

  // reference state, from requirements
  logic [7:0] m_port = 8'hDF;
  logic [3:0] m_low  = '0;
  int         m_cnt  = 0;

  always @(posedge clk) begin
    cyc++;
    #(CLK_PERIOD/4);
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (rst_line !== e.rst || gate !== e.gt || rdata !== e.rd || addr_q !== e.ad) begin
        bad++;
        $display("FAIL %s: rst=%b gate=%b rd=%h addr=%h, expected rst=%b gate=%b rd=%h addr=%h",
                 e.tag, rst_line, gate, rdata, addr_q, e.rst, e.gt, e.rd, e.ad);
      end
    end
  end

  task automatic tick(input logic w, input logic [7:0] wd, input logic r,
                      input logic [3:0] m, input logic [AW-1:0] a, input string tag);
    exp_t e;
    logic g_now;
    we = w; wdata = wd; req = r; mask = m; addr = a;
    g_now = m_port[1] & ~m_low[1];
    e.ad  = g_now ? a : (a & ~(AW'(1) << 20));
    if (w) m_port = wd;
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) m_low = '0;
    end else if (r && m != 4'hF) begin
      m_low = ~m;
      m_cnt = PULS;
    end
    e.due = cyc + 1;
    e.tag = tag;
    e.rst = m_port[0] & ~m_low[0];
    e.gt  = m_port[1] & ~m_low[1];
    e.rd  = m_port;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [AW-1:0] a, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 8'h00, 1'b0, 4'hF, a + AW'(i), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1: reset state before any edge with reset released
    total++;
    if (rdata !== 8'hDF || rst_line !== 1'b1 || gate !== 1'b1 || addr_q !== '0) begin
      bad++;
      $display("FAIL R1: rd=%h rst=%b gate=%b addr=%h, expected DF 1 1 0", rdata, rst_line, gate, addr_q);
    end
    rst_n = 1'b1;
    @(negedge clk);

    idle(4, 24'h1F_0000, "R8 pass, bit20 set");
    idle(2, 24'h0A_BCDE, "R8 pass, bit20 clear");
    tick(1'b1, 8'h5A, 1'b0, 4'hF, 24'h10_0001, "R2 write 5A");
    idle(3, 24'h12_3456, "R3 reset line follows bit0");
    tick(1'b1, 8'hDD, 1'b0, 4'hF, 24'h10_0000, "R2 write DD");
    idle(4, 24'h1F_FFF0, "R7 wrap with gate closed");
    tick(1'b1, 8'hDF, 1'b0, 4'hF, 24'h00_0000, "R2 write DF");
    idle(2, 24'h10_0000, "R8 gate reopened");

    tick(1'b0, 8'h00, 1'b1, 4'b1110, 24'h00_0000, "R4 start bit0 pulse");
    idle(PULS + 3, 24'h10_0100, "R4 bit0 pulse window");

    tick(1'b0, 8'h00, 1'b1, 4'b1101, 24'h10_0000, "R9 start bit1 pulse");
    idle(PULS + 3, 24'h1A_0000, "R9 wrap during gate pulse");

    tick(1'b0, 8'h00, 1'b1, 4'hF, 24'h10_0000, "R5 all-ones mask");
    idle(2, 24'h10_0000, "R5 no pulse");
    tick(1'b0, 8'h00, 1'b1, 4'b1011, 24'h10_0000, "R5 bit2 pulse leaves rst and gate");
    idle(5, 24'h10_0000, "R5 unselected bits steady");
    tick(1'b0, 8'h00, 1'b1, 4'b1100, 24'h10_0000, "R6 command during pulse");
    idle(4, 24'h11_0000, "R6 ignored command");
    tick(1'b1, 8'hDD, 1'b0, 4'hF, 24'h10_0000, "R10 write during pulse");
    idle(PULS, 24'h10_0000, "R10 stored byte vs pulse");
    idle(3, 24'h10_0000, "R6 no late pulse");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule